// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the slave-side logic that lets a device share an SMBus alert line with other devices. An alert event is latched. While that latched condition is present and no mask hides it, the block pulls the open-drain alert line low. The line is the wired-AND of every device's pull-down, so the host sees it low whenever any device is alerting.

The host answers a low alert line with a read of the alert response address (0001100 followed by a read bit). Each device that is pulling the alert line low acknowledges that byte. It then sends its own 7-bit address on the shared data line, most significant bit first, and checks the line after every bit it sends. A device that sends a 1 but reads back a 0 has lost and stops driving at once. The device that gets its whole address out unopposed does three things:

- it releases its alert pull-down;
- it clears its latched condition;
- it sets a mask bit that keeps the alert released until software clears the mask.

A mode input disables the response altogether.

Top module: `smb_alert_responder`

## Requirements
- R1: `alert_drive_low` is 1 exactly when a latched alert event is pending and the mask bit is clear. A mask-clear strobe with no pending event leaves the output at 0.
- R2: The block acknowledges only a START followed by the byte 0001100 then read (1), with address bits taken MSB first on SCL rising edges. A write bit (0) or any other address gets no acknowledge: the data line stays released on the ninth clock.
- R3: The block acknowledges (pulls SDA low during the ninth clock) only if it was pulling the alert line low when the START was seen.
- R4: After the acknowledge, the block sends its address parameter MSB first, pulling SDA low for a 0 and releasing it for a 1. It starts a pull-down only while synchronized SCL is low. It releases SDA for the eighth bit, which reads back as 1.
- R5: If the block reads SDA low while it is sending a 1, it releases SDA, keeps its alert asserted and leaves its mask clear. On the shared line the lower address wins.
- R6: After all seven address bits go out without a mismatch, the block releases its alert line, clears the pending event and sets the mask bit. It leaves SDA released for the master's NACK.
- R7: While the mask bit is set, the alert output stays released even when new events arrive. A mask-clear strobe clears the mask, and an event that arrived while masked then drives the alert line.
- R8: When `resp_disable` is 1 at the START, the block never drives SDA during that transfer.
- R9: A STOP aborts any transfer in progress and returns the block to idle, and the next START is decoded normally.
- R10: After reset, the mask is clear, no event is pending, and both pull-down outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | SMBus clock level (asynchronous) |
| sda_in | input | 1 | SMBus data level (asynchronous, wired-AND) |
| alert_event | input | 1 | One-cycle strobe that latches an alert condition |
| mask_clear | input | 1 | One-cycle software strobe that clears the mask bit |
| resp_disable | input | 1 | 1 disables the alert response protocol |
| sda_drive_low | output | 1 | Pull-down enable for the SDA line |
| alert_drive_low | output | 1 | Pull-down enable for the alert line |

## Verification
The assertions assume that SCL and SDA follow the bus rules. The master changes SDA only while SCL is low, except to form a START or a STOP. SCL stays in each level for many system clocks, so after synchronization the block never sees a clock edge and a data edge in the wrong order. The assertions also assume that the strobes are single-cycle pulses.

The bench master holds SCL low and high for 40 system clocks each and sets its data two clocks after the falling edge. A competing responder is modelled on the wired-AND line. It too changes its level only while SCL is low, and it drops out after the first bit it loses.

// File: rtl/smb_alert_responder.sv
module smb_alert_responder #(
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter logic [6:0] RESP_ADDR   = 7'b0001100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic alert_event,
  input  logic mask_clear,
  input  logic resp_disable,
  output logic sda_drive_low,
  output logic alert_drive_low
);

  localparam logic [7:0] MATCH_BYTE = {RESP_ADDR, 1'b1};

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK_WAIT, S_ACK, S_SEND, S_DONE
  } st_t;

  logic [SYNC_STAGES:0] scl_pipe, sda_pipe;
  logic scl_s, scl_q, sda_s, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  st_t        state;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [6:0] tx_sh;
  logic       sda_oe, joined, pending, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_in};
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign scl_q     = scl_pipe[SYNC_STAGES];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign sda_q     = sda_pipe[SYNC_STAGES];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  assign alert_drive_low = pending & ~mask_q;
  assign sda_drive_low   = sda_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      sda_oe  <= 1'b0;
      joined  <= 1'b0;
      pending <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      if (mask_clear) mask_q <= 1'b0;

      if (start_det) begin
        state   <= S_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        joined  <= alert_drive_low & ~resp_disable;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR: if (scl_rise) begin
            rx_sh <= {rx_sh[5:0], sda_s};
            if (bit_cnt == 3'd7) begin
              bit_cnt <= '0;
              state   <= ({rx_sh, sda_s} == MATCH_BYTE && joined) ? S_ACK_WAIT : S_IDLE;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
          S_ACK_WAIT: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= S_ACK;
          end
          S_ACK: if (scl_fall) begin
            sda_oe  <= ~DEV_ADDR[6];
            tx_sh   <= DEV_ADDR;
            bit_cnt <= '0;
            state   <= S_SEND;
          end
          S_SEND: begin
            if (scl_rise) begin
              if (tx_sh[6] && !sda_s) begin
                sda_oe <= 1'b0;
                state  <= S_IDLE;
              end else if (bit_cnt == 3'd6) begin
                state   <= S_DONE;
                mask_q  <= 1'b1;
                pending <= 1'b0;
              end else begin
                bit_cnt <= bit_cnt + 3'd1;
                tx_sh   <= {tx_sh[5:0], 1'b0};
              end
            end else if (scl_fall) begin
              sda_oe <= ~tx_sh[6];
            end
          end
          S_DONE: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end

      if (alert_event) pending <= 1'b1;
    end
  end

endmodule

module smb_alert_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic resp_disable,
  input logic mask_clear,
  input logic mask_q,
  input logic sda_drive_low,
  input logic alert_drive_low
);

  logic dis_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dis_seen <= 1'b0;
    else if (start_det) dis_seen <= resp_disable;
    else if (stop_det) dis_seen <= 1'b0;
  end

  p_pull_while_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_s);

  p_disabled_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dis_seen |-> !sda_drive_low);

  p_mask_hides_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !alert_drive_low);

  p_mask_from_alerting_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_q) |-> $past(alert_drive_low));

  p_unmask_by_software_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mask_q) |-> $past(mask_clear));

endmodule

bind smb_alert_responder smb_alert_responder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .resp_disable(resp_disable), .mask_clear(mask_clear),
  .mask_q(mask_q), .sda_drive_low(sda_drive_low),
  .alert_drive_low(alert_drive_low)
);

// File: tb/smb_alert_responder_tb.sv
`timescale 1ns/1ps
module smb_alert_responder_tb_top;
  localparam logic [6:0] DUT_ADDR = 7'h4C;
  localparam logic [6:0] ARA      = 7'b0001100;
  localparam int HALF = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, oth_low = 1'b0;
  logic alert_event = 1'b0, mask_clear = 1'b0, resp_disable = 1'b0;
  logic sda_drive_low, alert_drive_low, sda_line;

  assign sda_line = m_sda & ~oth_low & ~sda_drive_low;

  smb_alert_responder #(.DEV_ADDR(DUT_ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .alert_event(alert_event), .mask_clear(mask_clear),
    .resp_disable(resp_disable), .sda_drive_low(sda_drive_low),
    .alert_drive_low(alert_drive_low)
  );

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0)
      chk(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_cond();
    m_sda = 1'b1; wait_n(4);
    m_scl = 1'b1; wait_n(HALF);
    m_sda = 1'b0; wait_n(HALF);
    m_scl = 1'b0; wait_n(2);
  endtask

  task automatic stop_cond();
    m_sda = 1'b0; wait_n(HALF);
    m_scl = 1'b1; wait_n(HALF);
    m_sda = 1'b1; wait_n(HALF);
  endtask

  task automatic xfer_bit(input logic b, input logic ob, output logic r);
    m_sda = b; oth_low = ~ob; wait_n(HALF);
    m_scl = 1'b1; wait_n(HALF/2);
    r = sda_line; wait_n(HALF/2);
    m_scl = 1'b0; wait_n(2);
  endtask

  task automatic ara(input logic [6:0] a, input logic rw, input logic dut_join,
                     input logic oth_join, input logic [6:0] oth_a, input string tag);
    logic r;
    logic [7:0] hdr, got, ob8, db8, ex;
    logic live;
    hdr = {a, rw};
    start_cond();
    for (int i = 7; i >= 0; i--) xfer_bit(hdr[i], 1'b1, r);
    xfer_bit(1'b1, ~oth_join, r);
    exp_q.push_back({7'b0, ~(dut_join | oth_join)});
    tag_q.push_back({tag, " ack"});
    act_q.push_back({7'b0, r});
    if (dut_join | oth_join) begin
      ob8 = {oth_a, 1'b1}; db8 = {DUT_ADDR, 1'b1};
      live = oth_join; got = '0;
      for (int i = 7; i >= 0; i--) begin
        xfer_bit(1'b1, live ? ob8[i] : 1'b1, r);
        if (live && ob8[i] && !r) live = 1'b0;
        got[i] = r;
      end
      if (dut_join && oth_join) ex = (db8 < ob8) ? db8 : ob8;
      else ex = dut_join ? db8 : ob8;
      exp_q.push_back(ex); tag_q.push_back({tag, " byte"}); act_q.push_back(got);
      xfer_bit(1'b1, 1'b1, r);
    end
    oth_low = 1'b0;
    stop_cond();
  endtask

  task automatic pulse_event();
    alert_event = 1'b1; wait_n(1); alert_event = 1'b0; wait_n(2);
  endtask

  task automatic pulse_clear();
    mask_clear = 1'b1; wait_n(1); mask_clear = 1'b0; wait_n(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic r;
    wait_n(5);
    chk("R10 alert after reset", {7'b0, alert_drive_low}, 8'h00);
    chk("R10 sda after reset", {7'b0, sda_drive_low}, 8'h00);
    rst_n = 1'b1; wait_n(5);

    ara(ARA, 1'b1, 1'b0, 1'b0, 7'h00, "R3 no alert no ack");

    pulse_event();
    chk("R1 alert on event", {7'b0, alert_drive_low}, 8'h01);

    ara(ARA, 1'b0, 1'b0, 1'b0, 7'h00, "R2 write bit ignored");
    ara(7'h0D, 1'b1, 1'b0, 1'b0, 7'h00, "R2 other address ignored");
    chk("R2 alert kept", {7'b0, alert_drive_low}, 8'h01);

    resp_disable = 1'b1;
    ara(ARA, 1'b1, 1'b0, 1'b0, 7'h00, "R8 disabled no ack");
    chk("R8 alert kept", {7'b0, alert_drive_low}, 8'h01);
    resp_disable = 1'b0;

    ara(ARA, 1'b1, 1'b1, 1'b1, 7'h18, "R5 lose to lower addr");
    chk("R5 alert kept after loss", {7'b0, alert_drive_low}, 8'h01);

    ara(ARA, 1'b1, 1'b1, 1'b0, 7'h00, "R4 sole responder");
    chk("R6 alert released after win", {7'b0, alert_drive_low}, 8'h00);

    pulse_event();
    chk("R7 masked alert stays released", {7'b0, alert_drive_low}, 8'h00);
    ara(ARA, 1'b1, 1'b0, 1'b0, 7'h00, "R7 masked no ack");
    pulse_clear();
    chk("R7 pending event shows after clear", {7'b0, alert_drive_low}, 8'h01);

    ara(ARA, 1'b1, 1'b1, 1'b1, 7'h5A, "R5 win over higher addr");
    chk("R6 alert released after arbitrated win", {7'b0, alert_drive_low}, 8'h00);
    pulse_clear();
    chk("R1 clear with nothing pending", {7'b0, alert_drive_low}, 8'h00);

    pulse_event();
    start_cond();
    for (int i = 0; i < 3; i++) xfer_bit(ARA[6-i], 1'b1, r);
    stop_cond();
    chk("R9 alert kept after abort", {7'b0, alert_drive_low}, 8'h01);
    ara(ARA, 1'b1, 1'b1, 1'b0, 7'h00, "R9 after stop abort");
    chk("R9 alert released", {7'b0, alert_drive_low}, 8'h00);

    wait_n(10);
    while (exp_q.size() > 0) wait_n(1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule